// File: doc/BRIEF.md
# Progressive-Scan CCD Timing Generator

This block produces all digital drive timing for an interline CCD sensor that reads every pixel once per frame with no interlace. The timing comes from one pixel clock. Two counters track the clock within a line and the line within a frame. A decode stage turns each position into registered logic levels that go to the external vertical driver and the horizontal clock buffers. Those levels are: line and frame sync, three active-low vertical transfer phases, the charge readout pulse, the electronic-shutter drain pulse, two complementary horizontal phases, a reset-gate strobe, and a blanking flag.

Active lines come first in each frame and vertical blanking lines follow. The last line of the frame is the readout line. In that line the normal one-step vertical transfer is replaced by a long window in which phases 2 and 3 are driven together, and the readout pulse is nested inside that window at fixed clock offsets.

Exposure is set by a shutter value N, counted in lines. The block issues a drain pulse in the horizontal blanking of each line that lies more than N lines before the readout line. N = 0 turns the shutter off, which gives a full-frame exposure. N is sampled only at the first clock of a frame.

Every output is a registered level. The outputs seen after the k-th clock edge following reset release belong to position k of the frame: position 1 is line 1, clock 1, and positions advance one pixel clock per edge.

Top module: `ccd_timing_gen`

## Requirements
- R1: Each line lasts LINE_CLKS clocks. `hdN` is low on clocks 1..HD_W of every line and high on the others.
- R2: Each frame lasts FRAME_LINES lines. `vdN` is low for every clock of lines 1..VD_W and high on the others.
- R3: On every line except the last, `xv1N`, `xv2N` and `xv3N` go low in that order, each for VT_SEG clocks, starting at clock VT_START. Apart from that, all three stay high and at most one is low at a time.
- R4: On the last line of the frame (the readout line), `xv1N` stays high. `xv2N` and `xv3N` are both low on clocks RD_START..RD_START+RD_LEN-1 and high elsewhere.
- R5: `xsgN` is low only on the readout line, on clocks RD_START+SG_LEAD..RD_START+RD_LEN-1-SG_TRAIL. It is therefore always nested inside the window where `xv2N` and `xv3N` are low.
- R6: With shutter value N non-zero, `xsubN` is low on clocks SUB_START..SUB_START+SUB_W-1 of line L exactly when L is not the readout line and L + N < FRAME_LINES. Otherwise it stays high.
- R7: A shutter value of 0 keeps `xsubN` high on every line.
- R8: `shutterLines` is sampled only at line 1, clock 1. A change at any other point has no effect until the next frame starts.
- R9: Inside the active pixel window (clocks HACT_START..HACT_START+HACT_LEN-1), `h1` and `h2` are complementary: `h1` is high on even offsets from HACT_START and low on odd offsets. Outside the window, `h1` is parked high and `h2` low.
- R10: `rg` is high for one clock per pixel pair, on the clocks where `h1` is high inside the window, and low everywhere else.
- R11: `blank` is high outside the active pixel window and on every line above ACT_LINES.
- R12: While `rst` is high (synchronous), all active-low outputs are high, `h1` is high, `h2` and `rg` are low and `blank` is high. After release, timing restarts at line 1, clock 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| shutterLines | input | $clog2(FRAME_LINES+1) | Shutter value N in lines, 0 disables |
| hdN | output | 1 | Line sync, active low |
| vdN | output | 1 | Frame sync, active low |
| xv1N | output | 1 | Vertical transfer phase 1 control, active low |
| xv2N | output | 1 | Vertical transfer phase 2 control, active low |
| xv3N | output | 1 | Vertical transfer phase 3 control, active low |
| xsgN | output | 1 | Charge readout pulse, active low |
| xsubN | output | 1 | Shutter drain pulse, active low |
| h1 | output | 1 | Horizontal transfer phase 1 |
| h2 | output | 1 | Horizontal transfer phase 2 |
| rg | output | 1 | Reset-gate strobe |
| blank | output | 1 | Blanking flag |

## Verification
The bench builds the block with a 60-clock line and a 10-line frame, of which 6 lines are active. All windows are scaled down to fit inside that line. A full frame is then only 600 clocks, so dozens of frames, shutter changes made mid-frame, and the corner values N = 0, N = 1, N = FRAME_LINES-1 and N above the frame length all fit in a short run. Because the same decode serves any line length, checking every output at every position on the small geometry covers the behaviour of the default 780 x 525 geometry.

// File: rtl/ccdtg_pkg.sv
package ccdtg_pkg;

  // Position strobes passed from the counter control to the output datapath
  typedef struct packed {
    logic       frameStart;  // line 1, clock 1
    logic       hdWin;       // line sync window
    logic       vdLine;      // frame sync lines
    logic       readLine;    // last line of the frame
    logic       actLine;     // line carries image pixels
    logic [2:0] vtSeg;       // one-hot normal transfer segment
    logic       subWin;      // drain pulse window inside blanking
    logic       rdWin;       // merged phase 2/3 readout window
    logic       sgWin;       // readout pulse window
    logic       pixWin;      // active pixel window
    logic       pixFirst;    // first clock of a pixel pair
  } ccdStrobe_t;

endpackage

// File: rtl/ccdtg_ctrl.sv
module ccdtg_ctrl
  import ccdtg_pkg::*;
#(
  parameter int LINE_CLKS   = 780,
  parameter int FRAME_LINES = 525,
  parameter int ACT_LINES   = 494,
  parameter int HD_W        = 64,
  parameter int VD_W        = 3,
  parameter int VT_START    = 20,
  parameter int VT_SEG      = 24,
  parameter int SUB_START   = 96,
  parameter int SUB_W       = 30,
  parameter int RD_START    = 40,
  parameter int RD_LEN      = 520,
  parameter int SG_LEAD     = 31,
  parameter int SG_TRAIL    = 25,
  parameter int HACT_START  = 133,
  parameter int HACT_LEN    = 646,
  localparam int HW = $clog2(LINE_CLKS + 1),
  localparam int LW = $clog2(FRAME_LINES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  output ccdStrobe_t    strb,
  output logic [LW-1:0] lineNum
);

  localparam logic [HW-1:0] H_ONE  = HW'(1);
  localparam logic [HW-1:0] H_LAST = HW'(LINE_CLKS);
  localparam logic [LW-1:0] L_ONE  = LW'(1);
  localparam logic [LW-1:0] L_LAST = LW'(FRAME_LINES);
  localparam int SG_LO = RD_START + SG_LEAD;
  localparam int SG_HI = RD_START + RD_LEN - 1 - SG_TRAIL;

  logic [HW-1:0] hCnt;
  logic [LW-1:0] vCnt;
  logic [2:0]    segHit;
  logic          isReadLine;

  function automatic logic inWin(input logic [HW-1:0] c, input int lo, input int hi);
    return (int'(c) >= lo) && (int'(c) <= hi);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      hCnt <= H_ONE;
      vCnt <= L_ONE;
    end else if (hCnt == H_LAST) begin
      hCnt <= H_ONE;
      vCnt <= (vCnt == L_LAST) ? L_ONE : vCnt + L_ONE;
    end else begin
      hCnt <= hCnt + H_ONE;
    end
  end

  assign isReadLine = (vCnt == L_LAST);

  // One comparator pair per vertical transfer segment
  for (genvar k = 0; k < 3; k++) begin : g_seg
    localparam int SEG_LO = VT_START + k * VT_SEG;
    localparam int SEG_HI = VT_START + (k + 1) * VT_SEG - 1;
    assign segHit[k] = !isReadLine && inWin(hCnt, SEG_LO, SEG_HI);
  end

  always_comb begin
    strb.frameStart = (hCnt == H_ONE) && (vCnt == L_ONE);
    strb.hdWin      = inWin(hCnt, 1, HD_W);
    strb.vdLine     = (int'(vCnt) <= VD_W);
    strb.readLine   = isReadLine;
    strb.actLine    = (int'(vCnt) <= ACT_LINES);
    strb.vtSeg      = segHit;
    strb.subWin     = inWin(hCnt, SUB_START, SUB_START + SUB_W - 1);
    strb.rdWin      = isReadLine && inWin(hCnt, RD_START, RD_START + RD_LEN - 1);
    strb.sgWin      = isReadLine && inWin(hCnt, SG_LO, SG_HI);
    strb.pixWin     = inWin(hCnt, HACT_START, HACT_START + HACT_LEN - 1);
    strb.pixFirst   = (hCnt[0] == H_ONE[0]) ^ (((HACT_START % 2) == 0) ? 1'b1 : 1'b0);
  end

  assign lineNum = vCnt;

  AST_HCNT_WRAP: assert property (@(posedge clk) disable iff (rst) (hCnt == H_LAST) |=> (hCnt == H_ONE)); // R1
  AST_HCNT_RANGE: assert property (@(posedge clk) disable iff (rst) (hCnt >= H_ONE) && (hCnt <= H_LAST)); // R1
  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst) (hCnt == H_LAST && vCnt == L_LAST) |=> (vCnt == L_ONE)); // R2
  AST_ONE_SEGMENT: assert property (@(posedge clk) disable iff (rst) $onehot0(segHit)); // R3
  AST_SG_IN_READ: assert property (@(posedge clk) disable iff (rst) strb.sgWin |-> strb.rdWin); // R5

endmodule

// File: rtl/ccdtg_drive.sv
module ccdtg_drive
  import ccdtg_pkg::*;
#(
  parameter int FRAME_LINES = 525,
  localparam int LW = $clog2(FRAME_LINES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  ccdStrobe_t    strb,
  input  logic [LW-1:0] lineNum,
  input  logic [LW-1:0] shutterLines,
  output logic          hdN,
  output logic          vdN,
  output logic          xv1N,
  output logic          xv2N,
  output logic          xv3N,
  output logic          xsgN,
  output logic          xsubN,
  output logic          h1,
  output logic          h2,
  output logic          rg,
  output logic          blank
);

  logic [LW-1:0] shutShadow;
  logic          subFire;
  logic          xv1Nxt, xv2Nxt, xv3Nxt;

  // Exposure setting is frozen for the whole frame
  always_ff @(posedge clk) begin
    if (rst)                  shutShadow <= '0;
    else if (strb.frameStart) shutShadow <= shutterLines;
  end

  always_comb begin
    subFire = strb.subWin && !strb.readLine && (shutShadow != '0)
              && ((int'(lineNum) + int'(shutShadow)) < FRAME_LINES);
    if (strb.readLine) begin
      xv1Nxt = 1'b1;
      xv2Nxt = !strb.rdWin;
      xv3Nxt = !strb.rdWin;
    end else begin
      xv1Nxt = !strb.vtSeg[0];
      xv2Nxt = !strb.vtSeg[1];
      xv3Nxt = !strb.vtSeg[2];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hdN   <= 1'b1;
      vdN   <= 1'b1;
      xv1N  <= 1'b1;
      xv2N  <= 1'b1;
      xv3N  <= 1'b1;
      xsgN  <= 1'b1;
      xsubN <= 1'b1;
      h1    <= 1'b1;
      h2    <= 1'b0;
      rg    <= 1'b0;
      blank <= 1'b1;
    end else begin
      hdN   <= !strb.hdWin;
      vdN   <= !strb.vdLine;
      xv1N  <= xv1Nxt;
      xv2N  <= xv2Nxt;
      xv3N  <= xv3Nxt;
      xsgN  <= !strb.sgWin;
      xsubN <= !subFire;
      h1    <= strb.pixWin ? strb.pixFirst : 1'b1;
      h2    <= strb.pixWin && !strb.pixFirst;
      rg    <= strb.pixWin && strb.pixFirst;
      blank <= !strb.pixWin || !strb.actLine;
    end
  end

  AST_XV1_ALONE: assert property (@(posedge clk) disable iff (rst) !xv1N |-> (xv2N && xv3N)); // R3
  AST_XSG_NESTED: assert property (@(posedge clk) disable iff (rst) !xsgN |-> (!xv2N && !xv3N && xv1N)); // R5
  AST_SUB_NOT_READ: assert property (@(posedge clk) disable iff (rst) !xsubN |-> xsgN); // R6
  AST_SHUT_OFF: assert property (@(posedge clk) disable iff (rst) (shutShadow == '0 && !strb.frameStart) |=> xsubN); // R7
  AST_SHUT_HOLD: assert property (@(posedge clk) disable iff (rst) !strb.frameStart |=> $stable(shutShadow)); // R8
  AST_H_COMPL: assert property (@(posedge clk) disable iff (rst) h1 != h2); // R9
  AST_RG_WITH_H1: assert property (@(posedge clk) disable iff (rst) rg |-> (h1 && blank == blank)); // R10

endmodule

// File: rtl/ccd_timing_gen.sv
module ccd_timing_gen
  import ccdtg_pkg::*;
#(
  parameter int LINE_CLKS   = 780,
  parameter int FRAME_LINES = 525,
  parameter int ACT_LINES   = 494,
  parameter int HD_W        = 64,
  parameter int VD_W        = 3,
  parameter int VT_START    = 20,
  parameter int VT_SEG      = 24,
  parameter int SUB_START   = 96,
  parameter int SUB_W       = 30,
  parameter int RD_START    = 40,
  parameter int RD_LEN      = 520,
  parameter int SG_LEAD     = 31,
  parameter int SG_TRAIL    = 25,
  parameter int HACT_START  = 133,
  parameter int HACT_LEN    = 646,
  localparam int LW = $clog2(FRAME_LINES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] shutterLines,
  output logic          hdN,
  output logic          vdN,
  output logic          xv1N,
  output logic          xv2N,
  output logic          xv3N,
  output logic          xsgN,
  output logic          xsubN,
  output logic          h1,
  output logic          h2,
  output logic          rg,
  output logic          blank
);

  ccdStrobe_t    strb;
  logic [LW-1:0] lineNum;

  ccdtg_ctrl #(
    .LINE_CLKS(LINE_CLKS), .FRAME_LINES(FRAME_LINES), .ACT_LINES(ACT_LINES),
    .HD_W(HD_W), .VD_W(VD_W), .VT_START(VT_START), .VT_SEG(VT_SEG),
    .SUB_START(SUB_START), .SUB_W(SUB_W), .RD_START(RD_START), .RD_LEN(RD_LEN),
    .SG_LEAD(SG_LEAD), .SG_TRAIL(SG_TRAIL), .HACT_START(HACT_START), .HACT_LEN(HACT_LEN)
  ) u_ctrl (
    .clk(clk), .rst(rst), .strb(strb), .lineNum(lineNum)
  );

  ccdtg_drive #(
    .FRAME_LINES(FRAME_LINES)
  ) u_drive (
    .clk(clk), .rst(rst), .strb(strb), .lineNum(lineNum), .shutterLines(shutterLines),
    .hdN(hdN), .vdN(vdN), .xv1N(xv1N), .xv2N(xv2N), .xv3N(xv3N),
    .xsgN(xsgN), .xsubN(xsubN), .h1(h1), .h2(h2), .rg(rg), .blank(blank)
  );

endmodule

// File: tb/ccd_timing_gen_tb.sv
`timescale 1ns/1ps
module ccd_timing_gen_tb;

  localparam int L    = 60;
  localparam int F    = 10;
  localparam int ACT  = 6;
  localparam int HDW  = 5;
  localparam int VDW  = 2;
  localparam int VTS  = 3;
  localparam int VTG  = 4;
  localparam int SBS  = 16;
  localparam int SBW  = 5;
  localparam int RDS  = 4;
  localparam int RDL  = 40;
  localparam int SGL  = 6;
  localparam int SGT  = 5;
  localparam int HAS  = 24;
  localparam int HAL  = 32;
  localparam int FC   = L * F;
  localparam int LW   = $clog2(F + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [LW-1:0] shutterLines = '0;
  logic hdN, vdN, xv1N, xv2N, xv3N, xsgN, xsubN, h1, h2, rg, blank;

  int checks = 0;
  int errors = 0;
  int k = 0;
  int latchedN = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ccd_timing_gen #(
    .LINE_CLKS(L), .FRAME_LINES(F), .ACT_LINES(ACT), .HD_W(HDW), .VD_W(VDW),
    .VT_START(VTS), .VT_SEG(VTG), .SUB_START(SBS), .SUB_W(SBW),
    .RD_START(RDS), .RD_LEN(RDL), .SG_LEAD(SGL), .SG_TRAIL(SGT),
    .HACT_START(HAS), .HACT_LEN(HAL)
  ) u_dut (
    .clk(clk), .rst(rst), .shutterLines(shutterLines),
    .hdN(hdN), .vdN(vdN), .xv1N(xv1N), .xv2N(xv2N), .xv3N(xv3N),
    .xsgN(xsgN), .xsubN(xsubN), .h1(h1), .h2(h2), .rg(rg), .blank(blank)
  );

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b (step %0d)", req, what, act, exp, k);
    end
  endtask

  function automatic bit inR(input int c, input int lo, input int hi);
    return (c >= lo) && (c <= hi);
  endfunction

  // Expected outputs for frame position p (0-based) with shutter n
  task automatic checkPos(input int p, input int n);
    int c, ln;
    bit rdL, w, pw, first, sub;
    c   = p % L + 1;
    ln  = (p / L) % F + 1;
    rdL = (ln == F);
    chk(hdN, !inR(c, 1, HDW), "R1", "hdN");
    chk(vdN, !(ln <= VDW), "R2", "vdN");
    if (rdL) begin
      w = inR(c, RDS, RDS + RDL - 1);
      chk(xv1N, 1'b1, "R4", "xv1N");
      chk(xv2N, !w, "R4", "xv2N");
      chk(xv3N, !w, "R4", "xv3N");
      chk(xsgN, !inR(c, RDS + SGL, RDS + RDL - 1 - SGT), "R5", "xsgN");
    end else begin
      chk(xv1N, !inR(c, VTS, VTS + VTG - 1), "R3", "xv1N");
      chk(xv2N, !inR(c, VTS + VTG, VTS + 2 * VTG - 1), "R3", "xv2N");
      chk(xv3N, !inR(c, VTS + 2 * VTG, VTS + 3 * VTG - 1), "R3", "xv3N");
      chk(xsgN, 1'b1, "R5", "xsgN");
    end
    sub = !rdL && (n != 0) && (ln + n < F) && inR(c, SBS, SBS + SBW - 1);
    if (n == 0) chk(xsubN, 1'b1, "R7", "xsubN");
    else        chk(xsubN, !sub, "R6 R8", "xsubN");
    pw    = inR(c, HAS, HAS + HAL - 1);
    first = ((c - HAS) % 2) == 0;
    chk(h1, pw ? first : 1'b1, "R9", "h1");
    chk(h2, pw ? !first : 1'b0, "R9", "h2");
    chk(rg, pw && first, "R10", "rg");
    chk(blank, !pw || (ln > ACT), "R11", "blank");
  endtask

  task automatic checkIdle();
    chk(hdN, 1'b1, "R12", "hdN");   chk(vdN, 1'b1, "R12", "vdN");
    chk(xv1N, 1'b1, "R12", "xv1N"); chk(xv2N, 1'b1, "R12", "xv2N");
    chk(xv3N, 1'b1, "R12", "xv3N"); chk(xsgN, 1'b1, "R12", "xsgN");
    chk(xsubN, 1'b1, "R12", "xsubN"); chk(h1, 1'b1, "R12", "h1");
    chk(h2, 1'b0, "R12", "h2");     chk(rg, 1'b0, "R12", "rg");
    chk(blank, 1'b1, "R12", "blank");
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      k++;
      @(negedge clk);
      if ((k - 1) % FC == 0) latchedN = int'(shutterLines);
      checkPos(k - 1, latchedN);
    end
  endtask

  task automatic holdReset(input int n);
    rst = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      checkIdle();
    end
    rst = 1'b0;
    k = 0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    holdReset(3);                     // R12 reset state
    run(2 * FC);                      // R7 shutter off
    run(FC / 2);
    shutterLines = LW'(3);            // R8 change mid-frame
    run(FC / 2 + 2 * FC);
    shutterLines = LW'(F - 1);        // full exposure, no drain
    run(FC);
    shutterLines = LW'(1);            // drain on all lines but the last two
    run(FC);
    shutterLines = LW'(15);           // beyond frame length
    run(FC);
    for (int i = 0; i < 20; i++) begin
      shutterLines = LW'($urandom_range(0, 12));
      run(int'($urandom_range(1, 2 * FC)));
    end
    shutterLines = LW'(2);
    holdReset(4);                     // R12 restart from line 1 clock 1
    run(FC + L);
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule